// File: doc/BRIEF.md
# CRC32C Copy and Check Engine

This block moves a byte stream from a source port to a destination port and computes a CRC32C (Castagnoli) checksum over the bytes as they pass. It has a check-only mode in which the source bytes are consumed and checksummed but nothing goes to the destination. Each job starts with a command. The command gives the byte count, an optional seed, the copy or check-only choice, and three mode bits: store, test and inline.

In store mode the finished checksum is either presented on a side result port or appended as four trailing bytes. When appended, the bytes follow the copied data on the destination port in copy mode. In check-only mode they go out on a separate write-back port. In test mode the finished checksum is compared against an expected value. That value comes either from a command input or from four extra bytes that follow the data on the source port. A one-cycle done pulse ends every job, and an error flag reports a failed comparison or an illegal command.

All three byte streams use valid/ready. A byte moves on a cycle where both valid and ready are high. A sender holds valid and data steady until that happens. In copy mode the source is a zero-latency pass-through: `src_ready` follows `dst_ready`, and `dst_valid` follows `src_valid`, so back-pressure on the destination stalls the source in the same cycle. Outside a data phase every ready and valid the block drives is low.

Top module: `crc_mover`

## Requirements
- R1: The checksum is CRC32C, processed LSB-first with reflected polynomial 0x82F63B78 and a final XOR of 0xFFFFFFFF. The register starts at 0xFFFFFFFF when no seed is given. The nine ASCII bytes "123456789" give 0xE3069283.
- R2: When `cmd_seed_en` is high, `cmd_seed` is loaded into the checksum register in place of 0xFFFFFFFF.
- R3: In copy mode (`cmd_copy`=1) each of the `cmd_len` data bytes appears once on the destination port, unchanged and in order, under any destination back-pressure.
- R4: In check-only mode (`cmd_copy`=0) `dst_valid` never rises and the data bytes are accepted as they arrive.
- R5: Store without inline raises `res_valid` together with `done`. `res_crc` then carries the checksum, with the first wire byte in bits 7:0.
- R6: Test without inline compares the checksum with `cmd_expect`. A mismatch sets `err` and a match leaves it low.
- R7: Test with inline takes four further source bytes after the data as the expected value, first byte into bits 7:0. These bytes are not checksummed and are not forwarded.
- R8: Store with inline in copy mode sends four more destination bytes after the data: the checksum, bits 7:0 first.
- R9: Store with inline in check-only mode sends the same four checksum bytes on the write-back port, bits 7:0 first. The destination port stays idle.
- R10: A command with store and test both set is illegal. In the cycle after acceptance, `done` and `err` are high, no source byte is taken and `res_valid` stays low.
- R11: A command with inline set but neither store nor test is illegal and is reported the same way as R10.
- R12: `done` and `err` rise in the same cycle. `err` stays high until the next command is accepted, and `cmd_ready` is low while a job runs.
- R13: A zero-length command checksums no bytes, so the result is the initial value XOR 0xFFFFFFFF (0x00000000 unseeded).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle; command accepted when both high |
| cmd_len | input | LEN_W | Number of data bytes |
| cmd_copy | input | 1 | 1: forward to destination, 0: check-only |
| cmd_store | input | 1 | Produce the checksum |
| cmd_test | input | 1 | Compare the checksum |
| cmd_inline | input | 1 | Use trailing stream bytes instead of side ports |
| cmd_seed_en | input | 1 | Use cmd_seed as initial value |
| cmd_seed | input | 32 | Seed value |
| cmd_expect | input | 32 | Expected checksum for test without inline |
| src_valid | input | 1 | Source byte valid |
| src_ready | output | 1 | Source byte taken |
| src_data | input | 8 | Source byte |
| dst_valid | output | 1 | Destination byte valid |
| dst_ready | input | 1 | Destination can take a byte |
| dst_data | output | 8 | Destination byte |
| wb_valid | output | 1 | Write-back byte valid (check-only inline store) |
| wb_ready | input | 1 | Write-back can take a byte |
| wb_data | output | 8 | Write-back byte |
| done | output | 1 | One-cycle end-of-job pulse |
| err | output | 1 | Job error, held until next command accepted |
| res_valid | output | 1 | Result present on res_crc, with done |
| res_crc | output | 32 | Checksum, first wire byte in bits 7:0 |

## Verification
The bench checks the standard check string and a seeded run. An engine with the wrong reflection, seed handling or final inversion returns a wrong `res_crc` on these runs. Destination and write-back back-pressure are toggled during data and trailer phases. Under that back-pressure, a pass-through that ignored ready would drop or duplicate bytes, and a trailer counter that advanced without a handshake would skip checksum bytes. The bench also drives inline test jobs with good and corrupted trailers. Of these, a design that checksummed or forwarded the trailer would report a false error or emit extra destination bytes. Illegal mode combinations and zero-length jobs are driven to catch a design that swallows source bytes or never raises done. After a failed job the bench watches `err` across idle cycles and through the next acceptance, which catches a flag that pulses instead of holding or fails to clear.

// File: rtl/crc_mover_pkg.sv
package crc_mover_pkg;
  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY_REV = 32'h82F63B78;
  localparam logic [CRC_W-1:0] CRC_INIT     = 32'hFFFFFFFF;
  localparam logic [CRC_W-1:0] CRC_XOUT     = 32'hFFFFFFFF;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_DATA = 3'd1,
    PH_TIN  = 3'd2,
    PH_TOUT = 3'd3,
    PH_FIN  = 3'd4
  } phase_t;

  typedef struct packed {
    logic copy;
    logic store;
    logic test;
    logic inl;
  } mode_t;

  function automatic logic mode_illegal(input mode_t m);
    return (m.store && m.test) || (m.inl && !m.store && !m.test);
  endfunction

  // Phase entered once all data bytes are through.
  function automatic phase_t tail_phase(input mode_t m);
    if (m.inl && m.test)  return PH_TIN;
    if (m.inl && m.store) return PH_TOUT;
    return PH_FIN;
  endfunction
endpackage

// File: rtl/crc32c_step.sv
module crc32c_step #(
  parameter int W = 32,
  parameter logic [W-1:0] POLY = 32'h82F63B78
) (
  input  logic [W-1:0] crc_i,
  input  logic [7:0]   byte_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] stage [9];
  assign stage[0] = crc_i;
  for (genvar b = 0; b < 8; b++) begin : g_bit
    assign stage[b+1] = (stage[b] >> 1) ^ ({W{stage[b][0] ^ byte_i[b]}} & POLY);
  end
  assign crc_o = stage[8];
endmodule

// File: rtl/crc_mover_route.sv
module crc_mover_route
  import crc_mover_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  phase_t     phase,
  input  logic       copy,
  input  logic [7:0] trail_byte,
  input  logic       src_valid,
  output logic       src_ready,
  input  logic [7:0] src_data,
  output logic       dst_valid,
  input  logic       dst_ready,
  output logic [7:0] dst_data,
  output logic       wb_valid,
  input  logic       wb_ready,
  output logic [7:0] wb_data,
  output logic       data_fire,
  output logic       tin_fire,
  output logic       tout_fire
);
  always_comb begin
    src_ready = 1'b0;
    dst_valid = 1'b0;
    dst_data  = 8'h00;
    wb_valid  = 1'b0;
    wb_data   = 8'h00;
    data_fire = 1'b0;
    tin_fire  = 1'b0;
    tout_fire = 1'b0;
    unique case (phase)
      PH_DATA: begin
        if (copy) begin
          dst_valid = src_valid;
          dst_data  = src_data;
          src_ready = dst_ready;
        end else begin
          src_ready = 1'b1;
        end
        data_fire = src_valid && src_ready;
      end
      PH_TIN: begin
        src_ready = 1'b1;
        tin_fire  = src_valid;
      end
      PH_TOUT: begin
        if (copy) begin
          dst_valid = 1'b1;
          dst_data  = trail_byte;
          tout_fire = dst_ready;
        end else begin
          wb_valid  = 1'b1;
          wb_data   = trail_byte;
          tout_fire = wb_ready;
        end
      end
      default: ;
    endcase
  end

  // R4
  dst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |-> copy);
  // R9
  wb_only_tout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (!copy && phase == PH_TOUT));
endmodule

// File: rtl/crc_mover_ctrl.sv
module crc_mover_ctrl
  import crc_mover_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [LEN_W-1:0] cmd_len,
  input  mode_t            cmd_mode,
  input  logic             cmd_seed_en,
  input  logic [CRC_W-1:0] cmd_seed,
  input  logic [CRC_W-1:0] cmd_expect,
  input  logic [7:0]       src_data,
  input  logic             data_fire,
  input  logic             tin_fire,
  input  logic             tout_fire,
  output phase_t           phase_o,
  output logic             copy_o,
  output logic [7:0]       trail_byte_o,
  output logic             done_o,
  output logic             err_o,
  output logic             res_valid_o,
  output logic [CRC_W-1:0] res_crc_o
);
  phase_t           phase_q;
  mode_t            mode_q;
  logic [LEN_W-1:0] len_q, cnt_q;
  logic [1:0]       idx_q;
  logic [CRC_W-1:0] crc_q, crc_nxt, crc_fin, exp_q;
  logic             done_q, err_q, resv_q;
  logic [CRC_W-1:0] res_q;
  logic             cmd_fire, last_byte;

  crc32c_step #(.W(CRC_W), .POLY(CRC_POLY_REV)) u_step (
    .crc_i (crc_q),
    .byte_i(src_data),
    .crc_o (crc_nxt)
  );

  assign crc_fin   = crc_q ^ CRC_XOUT;
  assign cmd_ready = (phase_q == PH_IDLE);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign last_byte = (cnt_q == len_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      mode_q  <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      crc_q   <= CRC_INIT;
      exp_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      resv_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      done_q <= 1'b0;
      resv_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (cmd_valid) begin
          mode_q <= cmd_mode;
          len_q  <= cmd_len;
          cnt_q  <= '0;
          idx_q  <= '0;
          crc_q  <= cmd_seed_en ? cmd_seed : CRC_INIT;
          exp_q  <= cmd_expect;
          if (mode_illegal(cmd_mode)) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else begin
            err_q   <= 1'b0;
            phase_q <= (cmd_len == '0) ? tail_phase(cmd_mode) : PH_DATA;
          end
        end
        PH_DATA: if (data_fire) begin
          crc_q <= crc_nxt;
          cnt_q <= cnt_q + 1'b1;
          if (last_byte) phase_q <= tail_phase(mode_q);
        end
        PH_TIN: if (tin_fire) begin
          exp_q[8*idx_q +: 8] <= src_data;
          idx_q <= idx_q + 2'd1;
          if (idx_q == 2'd3) phase_q <= PH_FIN;
        end
        PH_TOUT: if (tout_fire) begin
          idx_q <= idx_q + 2'd1;
          if (idx_q == 2'd3) phase_q <= PH_FIN;
        end
        PH_FIN: begin
          done_q  <= 1'b1;
          err_q   <= mode_q.test && (crc_fin != exp_q);
          resv_q  <= mode_q.store && !mode_q.inl;
          res_q   <= crc_fin;
          phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o      = phase_q;
  assign copy_o       = mode_q.copy;
  assign trail_byte_o = crc_fin[8*idx_q +: 8];
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign res_valid_o  = resv_q;
  assign res_crc_o    = res_q;

  // R10
  illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && mode_illegal(cmd_mode)) |=> (done_o && err_o && !res_valid_o && cmd_ready));
  // R12
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !cmd_fire) |=> err_o);
  // R5
  res_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> done_o);
  // R7
  tin_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_TIN) |-> (mode_q.test && mode_q.inl));
endmodule

// File: rtl/crc_mover.sv
module crc_mover
  import crc_mover_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             cmd_copy,
  input  logic             cmd_store,
  input  logic             cmd_test,
  input  logic             cmd_inline,
  input  logic             cmd_seed_en,
  input  logic [31:0]      cmd_seed,
  input  logic [31:0]      cmd_expect,
  input  logic             src_valid,
  output logic             src_ready,
  input  logic [7:0]       src_data,
  output logic             dst_valid,
  input  logic             dst_ready,
  output logic [7:0]       dst_data,
  output logic             wb_valid,
  input  logic             wb_ready,
  output logic [7:0]       wb_data,
  output logic             done,
  output logic             err,
  output logic             res_valid,
  output logic [31:0]      res_crc
);
  mode_t      mode;
  phase_t     phase;
  logic       copy_q, data_fire, tin_fire, tout_fire;
  logic [7:0] trail_byte;

  assign mode = '{copy: cmd_copy, store: cmd_store, test: cmd_test, inl: cmd_inline};

  crc_mover_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_len(cmd_len),
    .cmd_mode(mode), .cmd_seed_en(cmd_seed_en), .cmd_seed(cmd_seed),
    .cmd_expect(cmd_expect), .src_data(src_data),
    .data_fire(data_fire), .tin_fire(tin_fire), .tout_fire(tout_fire),
    .phase_o(phase), .copy_o(copy_q), .trail_byte_o(trail_byte),
    .done_o(done), .err_o(err), .res_valid_o(res_valid), .res_crc_o(res_crc)
  );

  crc_mover_route u_route (
    .clk(clk), .rst_n(rst_n),
    .phase(phase), .copy(copy_q), .trail_byte(trail_byte),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_data(dst_data),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_data(wb_data),
    .data_fire(data_fire), .tin_fire(tin_fire), .tout_fire(tout_fire)
  );

  // R8
  trail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TOUT && dst_valid && !dst_ready) |=> (dst_valid && $stable(dst_data)));
  // R12
  busy_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ready || dst_valid || wb_valid) |-> !cmd_ready);
endmodule

// File: tb/tb_crc_mover.sv
module tb_crc_mover;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic [15:0] cmd_len = '0;
  logic        cmd_copy = 1'b0, cmd_store = 1'b0, cmd_test = 1'b0, cmd_inline = 1'b0;
  logic        cmd_seed_en = 1'b0;
  logic [31:0] cmd_seed = '0, cmd_expect = '0;
  logic        src_valid = 1'b0, src_ready;
  logic [7:0]  src_data = '0;
  logic        dst_valid, dst_ready = 1'b1;
  logic [7:0]  dst_data;
  logic        wb_valid, wb_ready = 1'b1;
  logic [7:0]  wb_data;
  logic        done, err, res_valid;
  logic [31:0] res_crc;

  always #2 clk = ~clk;

  crc_mover dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_len(cmd_len), .cmd_copy(cmd_copy), .cmd_store(cmd_store), .cmd_test(cmd_test),
    .cmd_inline(cmd_inline), .cmd_seed_en(cmd_seed_en), .cmd_seed(cmd_seed),
    .cmd_expect(cmd_expect), .src_valid(src_valid), .src_ready(src_ready),
    .src_data(src_data), .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_data(dst_data),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_data(wb_data), .done(done), .err(err),
    .res_valid(res_valid), .res_crc(res_crc)
  );

  int checks = 0, failures = 0;
  string cur_req = "R0";
  logic [7:0]  dq[$], wq[$];
  logic        oq_err[$], oq_rv[$];
  logic [31:0] oq_crc[$];
  logic [7:0]  pat [0:63];
  logic [7:0]  lfsr = 8'hA5;
  bit          bp_mode = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_ref(input logic [31:0] init, input int n);
    logic [31:0] c = init;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ pat[i][b];
        c = c >> 1;
        if (fb) c = c ^ 32'h82F63B78;
      end
    return c ^ 32'hFFFFFFFF;
  endfunction

  // back-pressure on destination and write-back
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    dst_ready = bp_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
    wb_ready  = bp_mode ? (lfsr[1] | lfsr[6]) : 1'b1;
  end

  // monitor / scoreboard
  always @(negedge clk) if (rst_n) begin
    if (dst_valid && dst_ready) begin
      if (dq.size() == 0) chk(cur_req, "unexpected dst byte", {24'h0, dst_data}, 32'hxx);
      else chk(cur_req, "dst byte", {24'h0, dst_data}, {24'h0, dq.pop_front()});
    end
    if (wb_valid && wb_ready) begin
      if (wq.size() == 0) chk(cur_req, "unexpected wb byte", {24'h0, wb_data}, 32'hxx);
      else chk(cur_req, "wb byte", {24'h0, wb_data}, {24'h0, wq.pop_front()});
    end
    if (done) begin
      if (oq_err.size() == 0) chk(cur_req, "unexpected done", 32'd1, 32'd0);
      else begin
        logic e, rv;
        logic [31:0] rc;
        e = oq_err.pop_front(); rv = oq_rv.pop_front(); rc = oq_crc.pop_front();
        chk(cur_req, "err with done", {31'h0, err}, {31'h0, e});
        chk(cur_req, "res_valid", {31'h0, res_valid}, {31'h0, rv});
        if (rv) chk(cur_req, "res_crc", res_crc, rc);
        chk(cur_req, "bytes left at done", dq.size() + wq.size(), 32'd0);
      end
    end
  end

  task automatic feed(input logic [7:0] b, input int i);
    bit acc;
    if (bp_mode && (i % 3 == 1)) begin @(posedge clk); #1; end
    src_valid = 1'b1; src_data = b;
    do begin
      @(negedge clk); acc = src_ready;
      @(posedge clk); #1;
    end while (!acc);
    src_valid = 1'b0;
  endtask

  task automatic run_cmd(input int n, input bit seed_en, input logic [31:0] seed, input bit copy,
                         input bit store, input bit test, input bit inl, input bit good);
    logic [31:0] crc;
    logic [7:0]  tr [4];
    bit ill;
    ill = (store && test) || (inl && !store && !test);
    crc = crc_ref(seed_en ? seed : 32'hFFFFFFFF, n);
    for (int k = 0; k < 4; k++) tr[k] = crc[8*k +: 8];
    if (!good) tr[0] = tr[0] ^ 8'h80;
    if (!ill) begin
      if (copy) for (int i = 0; i < n; i++) dq.push_back(pat[i]);
      if (store && inl) for (int k = 0; k < 4; k++)
        if (copy) dq.push_back(tr[k]); else wq.push_back(tr[k]);
    end
    oq_err.push_back(ill || (test && !good));
    oq_rv.push_back(!ill && store && !inl);
    oq_crc.push_back(crc);
    @(posedge clk); #1;
    cmd_len = 16'(n); cmd_copy = copy; cmd_store = store; cmd_test = test; cmd_inline = inl;
    cmd_seed_en = seed_en; cmd_seed = seed; cmd_expect = good ? crc : crc ^ 32'h1;
    cmd_valid = 1'b1;
    @(negedge clk);
    chk("R12", "cmd_ready idle", {31'h0, cmd_ready}, 32'd1);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    @(negedge clk);
    if (ill) begin
      chk(cur_req, "src_ready after illegal", {31'h0, src_ready}, 32'd0);
    end else begin
      chk("R12", "cmd_ready busy", {31'h0, cmd_ready}, 32'd0);
      chk("R12", "err cleared on accept", {31'h0, err}, 32'd0);
    end
    @(posedge clk); #1;
    if (!ill) begin
      for (int i = 0; i < n; i++) feed(pat[i], i);
      if (test && inl) for (int k = 0; k < 4; k++) feed(tr[k], k);
    end
    while (oq_err.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R12 watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "reset cmd_ready", {31'h0, cmd_ready}, 32'd1);
    chk("R12", "reset done/err", {30'h0, done, err}, 32'd0);
    chk("R4", "reset dst/wb valid", {30'h0, dst_valid, wb_valid}, 32'd0);

    // R1 R3 R5: check string, copy with side result
    for (int i = 0; i < 64; i++) pat[i] = 8'h31 + 8'(i);
    cur_req = "R1";
    run_cmd(9, 0, 0, 1, 1, 0, 0, 1);
    chk("R1", "known check value", crc_ref(32'hFFFFFFFF, 9), 32'hE3069283);

    // R2 R3: seeded, back-pressure
    for (int i = 0; i < 64; i++) pat[i] = 8'(i * 37 + 5);
    bp_mode = 1'b1;
    cur_req = "R2";
    run_cmd(20, 1, 32'h12345678, 1, 1, 0, 0, 1);

    // R4 R6: check-only test side value, match then mismatch
    cur_req = "R6";
    run_cmd(17, 0, 0, 0, 0, 1, 0, 1);
    run_cmd(17, 0, 0, 0, 0, 1, 0, 0);
    repeat (3) @(negedge clk);
    chk("R12", "err held while idle", {31'h0, err}, 32'd1);

    // R7: inline test good and bad trailer, copy mode
    cur_req = "R7";
    run_cmd(11, 1, 32'h0BADF00D, 1, 0, 1, 1, 1);
    run_cmd(11, 0, 0, 1, 0, 1, 1, 0);

    // R8: inline store appended to destination
    cur_req = "R8";
    run_cmd(13, 0, 0, 1, 1, 0, 1, 1);

    // R9: inline store to write-back in check-only mode
    cur_req = "R9";
    run_cmd(6, 1, 32'hCAFEBABE, 0, 1, 0, 1, 1);
    bp_mode = 1'b0;

    // R10 R11: illegal commands
    cur_req = "R10";
    run_cmd(8, 0, 0, 1, 1, 1, 0, 1);
    cur_req = "R11";
    run_cmd(8, 0, 0, 1, 0, 0, 1, 1);

    // R13: zero length unseeded and seeded
    cur_req = "R13";
    run_cmd(0, 0, 0, 1, 1, 0, 0, 1);
    run_cmd(0, 1, 32'h00000000, 0, 1, 0, 0, 1);

    // R3: plain copy, no store/test
    cur_req = "R3";
    run_cmd(30, 0, 0, 1, 0, 0, 0, 1);

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule